// File: doc/BRIEF.md
# Split-Mode 64-bit Timer with Watchdog

This block is a general-purpose timer built around one 64-bit count held as two 32-bit halves. A control register selects one of four modes: off, a single 64-bit timer, two independent 32-bit timers, or a watchdog. In the timer modes each half counts either every clock or the rising edges of its own external input. The external input passes through a two-flop synchronizer and an edge detector. When the count equals the programmed period, the half raises a one-cycle event, restarts from zero and drives its output pin. The pin can produce a pulse of programmable width (never shorter than 12 clocks), or it can toggle on each match.

In watchdog mode the full 64-bit count is loaded from the period and falls by one every clock. Software must write a two-value key sequence to the service register before the count reaches zero. A correct sequence reloads the count. If the count reaches zero, a sticky expiry output and a reset request are raised, together with a reset kind taken from the control register. Once the watchdog mode is entered, no write can leave it or change the count. Only a reset does that.

Top module: `split_timer64`

## Requirements
- R1: After reset, every register reads 0 and all pin, event and reset outputs are low.
- R2: In 64-bit mode (control bits [1:0]=1) with the clock source (bit 2 = 0), the low event pulses once every P+1 clocks, where P = {period high (address 2), period low (address 1)}. The two halves carry as one 64-bit counter, read back at address 3 (low) and 4 (high).
- R3: With bit 2 = 1, the low half advances only on rising edges of the low input, so events come every P+1 edges. A steady input leaves the count unchanged.
- R4: In dual mode (bits [1:0]=2), the low half uses period-low, bit 2, the low input and the low pin. The high half uses period-high, bit 3, the high input and the high pin. The two halves count and raise events independently.
- R5: In 64-bit mode the high event and the high pin stay low.
- R6: In pulse form (bit 4 low half, bit 5 high half, value 0), each event drives the pin high for max(W,12) clocks, where W is the width register at address 5.
- R7: In toggle form (form bit = 1), the pin inverts on every event.
- R8: In watchdog mode (bits [1:0]=3), the count is loaded with P on entry and falls by one each clock. When it reaches 0, the expiry and reset-request outputs rise and stay high until reset. The reset-kind output mirrors control bits [7:6].
- R9: A write of 0xA5C6 to address 6 arms the service. A following write of 0xDA7E to the same address reloads the watchdog count with P. Any other value written there disarms it. A service after expiry changes nothing.
- R10: In watchdog mode, writes to the control register and to the count registers are ignored.
- R11: Writing mode 0 clears both count halves and stops counting. Outside watchdog mode, a write to address 3 or 4 loads that count half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tin_lo | input | 1 | External count input, low half |
| tin_hi | input | 1 | External count input, high half |
| tout_lo | output | 1 | Output pin, low half |
| tout_hi | output | 1 | Output pin, high half |
| evt_lo | output | 1 | One-cycle period event, low half / 64-bit |
| evt_hi | output | 1 | One-cycle period event, high half |
| wdog_evt | output | 1 | Sticky watchdog expiry |
| rst_req | output | 1 | Reset request on expiry |
| rst_kind | output | 2 | Requested reset kind |

## Verification
The counting function is driven with three kinds of input. Random small periods on the clock source show whether the match-and-restart interval is off by one. External square waves with random half-periods show that edges, not clocks, drive the count, and the same waves on the high input separate the two halves in dual mode. A preset count just below the 32-bit boundary shows whether the carry reaches the high half. For the watchdog, key writes in the correct order, in the wrong order and with a bad value are each followed by an exact count readback. That readback distinguishes a reload from a plain countdown.

// File: rtl/st64_pkg.sv
`timescale 1ns/1ps
// Shared types for the split timer: mode encoding and register addresses.
// Assumes a word-addressed register space of at least 3 address bits.
package st64_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_GEN64 = 2'd1,
        MODE_DUAL  = 2'd2,
        MODE_WDOG  = 2'd3
    } st_mode_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_PRD_LO = 1;
    localparam int ADDR_PRD_HI = 2;
    localparam int ADDR_CNT_LO = 3;
    localparam int ADDR_CNT_HI = 4;
    localparam int ADDR_WIDTH  = 5;
    localparam int ADDR_SVC    = 6;
endpackage

// File: rtl/st64_edge_sync.sv
`timescale 1ns/1ps
// Brings an asynchronous count input into the clock domain through two flops
// and emits a one-cycle pulse on each rising edge. Assumes the input stays
// high and low for at least a few clocks (12 required by the timer).
module st64_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [2:0] shift_q;

    // Two synchronizer stages plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[1:0], pin};
    end

    assign rise = shift_q[1] & ~shift_q[2];

    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/st64_out_shaper.sv
`timescale 1ns/1ps
// Turns period events into an output waveform: either a pulse of
// max(width, MIN_W) clocks per event, or a level that inverts per event.
// Assumes events in pulse form arrive no faster than the pulse length;
// an early event restarts the pulse.
module st64_out_shaper #(
    parameter int WW    = 8,
    parameter int MIN_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          evt,
    input  logic          toggle_form,
    input  logic [WW-1:0] width,
    output logic          pin
);
    localparam logic [WW-1:0] MIN_V = WW'(MIN_W);
    localparam logic [WW:0]   MIN_RUN = (WW+1)'(MIN_W);

    logic [WW-1:0] eff_w;
    logic [WW-1:0] remain_q;

    assign eff_w = (width < MIN_V) ? MIN_V : width;

    // Pin state and remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pin      <= 1'b0;
            remain_q <= '0;
        end else if (evt) begin
            if (toggle_form) begin
                pin <= ~pin;
            end else begin
                pin      <= 1'b1;
                remain_q <= eff_w - 1'b1;
            end
        end else if (!toggle_form && pin) begin
            if (remain_q == '0) pin <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
        end
    end

    // Checker state: length of the current high run, saturating.
    logic [WW:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                      hi_run_q <= '0;
        else if (!pin)                   hi_run_q <= '0;
        else if (hi_run_q != '1)         hi_run_q <= hi_run_q + 1'b1;
    end

    a_r6_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pin) && !toggle_form && !$past(clr)) |-> (hi_run_q >= MIN_RUN));
endmodule

// File: rtl/st64_counter.sv
`timescale 1ns/1ps
// Count datapath: two CW-bit halves that chain into one 2*CW counter,
// run as two independent up-counters, or form a down-counting watchdog.
// Assumes the control decode gives single-cycle clr, wd_load, svc_ok and
// load strobes, and never asserts loads in watchdog mode.
module st64_counter
    import st64_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  st_mode_e      mode,
    input  logic          clr,
    input  logic          wd_load,
    input  logic          svc_ok,
    input  logic [1:0]    tick,
    input  logic [1:0]    ld,
    input  logic [CW-1:0] ld_val,
    input  logic [2*CW-1:0] prd,
    output logic [CW-1:0] cnt_lo,
    output logic [CW-1:0] cnt_hi,
    output logic [1:0]    evt,
    output logic          expired
);
    localparam int DW = 2 * CW;

    logic [CW-1:0] cnt_q [2];
    logic [CW-1:0] prd_h [2];
    logic [DW-1:0] full;

    assign prd_h[0] = prd[CW-1:0];
    assign prd_h[1] = prd[DW-1:CW];
    assign full     = {cnt_q[1], cnt_q[0]};
    assign cnt_lo   = cnt_q[0];
    assign cnt_hi   = cnt_q[1];

    // Counting, match/restart, watchdog countdown and direct loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
            evt      <= '0;
            expired  <= 1'b0;
        end else begin
            evt <= '0;
            if (clr) begin
                cnt_q[0] <= '0;
                cnt_q[1] <= '0;
            end else if (wd_load) begin
                {cnt_q[1], cnt_q[0]} <= prd;
            end else begin
                unique case (mode)
                    MODE_GEN64: begin
                        if (tick[0]) begin
                            if (full == prd) begin
                                {cnt_q[1], cnt_q[0]} <= '0;
                                evt[0] <= 1'b1;
                            end else begin
                                {cnt_q[1], cnt_q[0]} <= full + 1'b1;
                            end
                        end
                    end
                    MODE_DUAL: begin
                        for (int h = 0; h < 2; h++) begin
                            if (tick[h]) begin
                                if (cnt_q[h] == prd_h[h]) begin
                                    cnt_q[h] <= '0;
                                    evt[h]   <= 1'b1;
                                end else begin
                                    cnt_q[h] <= cnt_q[h] + 1'b1;
                                end
                            end
                        end
                    end
                    MODE_WDOG: begin
                        if (!expired) begin
                            if (svc_ok) begin
                                {cnt_q[1], cnt_q[0]} <= prd;
                            end else if (full <= DW'(1)) begin
                                {cnt_q[1], cnt_q[0]} <= '0;
                                expired <= 1'b1;
                            end else begin
                                {cnt_q[1], cnt_q[0]} <= full - 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
                if (ld[0]) cnt_q[0] <= ld_val;
                if (ld[1]) cnt_q[1] <= ld_val;
            end
        end
    end

    a_r8_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);

    a_r5_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_GEN64 && mode == MODE_GEN64) |-> !evt[1]);
endmodule

// File: rtl/split_timer64.sv
`timescale 1ns/1ps
// Split-mode 64-bit timer with watchdog. Holds the register file, the
// watchdog key-sequence logic and the mode lock, and wires two input
// synchronizers, two output shapers and the count datapath together.
// Assumes register writes are single-cycle strobes and reads are combinational.
module split_timer64
    import st64_pkg::*;
#(
    parameter int          CW        = 32,
    parameter int          AW        = 4,
    parameter int          WW        = 8,
    parameter int          MIN_PULSE = 12,
    parameter logic [31:0] KEY_ARM   = 32'h0000_A5C6,
    parameter logic [31:0] KEY_FIRE  = 32'h0000_DA7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          tin_lo,
    input  logic          tin_hi,
    output logic          tout_lo,
    output logic          tout_hi,
    output logic          evt_lo,
    output logic          evt_hi,
    output logic          wdog_evt,
    output logic          rst_req,
    output logic [1:0]    rst_kind
);
    localparam int NH = 2;

    logic [7:0]    ctrl_q;
    logic [CW-1:0] prd_lo_q, prd_hi_q;
    logic [WW-1:0] width_q;
    logic          armed_q;

    st_mode_e      mode_q, new_mode;
    logic          locked, wr_ctrl, clr, wd_load, svc_wr, svc_ok;
    logic [NH-1:0] ld, tick, rise, evt, pins, tins;
    logic [CW-1:0] cnt_lo, cnt_hi;
    logic          expired;

    assign mode_q   = st_mode_e'(ctrl_q[1:0]);
    assign new_mode = st_mode_e'(wr_data[1:0]);
    assign locked   = (mode_q == MODE_WDOG);
    assign wr_ctrl  = wr_en && (wr_addr == AW'(ADDR_CTRL)) && !locked;
    assign clr      = wr_ctrl && (new_mode == MODE_OFF);
    assign wd_load  = wr_ctrl && (new_mode == MODE_WDOG);
    assign ld[0]    = wr_en && (wr_addr == AW'(ADDR_CNT_LO)) && !locked;
    assign ld[1]    = wr_en && (wr_addr == AW'(ADDR_CNT_HI)) && !locked;
    assign svc_wr   = wr_en && (wr_addr == AW'(ADDR_SVC));
    assign svc_ok   = svc_wr && armed_q && locked && (32'(wr_data) == KEY_FIRE);

    // Register file and service-key arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            prd_lo_q <= '0;
            prd_hi_q <= '0;
            width_q  <= '0;
            armed_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_ctrl)                             ctrl_q   <= wr_data[7:0];
            if (wr_addr == AW'(ADDR_PRD_LO))         prd_lo_q <= wr_data;
            if (wr_addr == AW'(ADDR_PRD_HI))         prd_hi_q <= wr_data;
            if (wr_addr == AW'(ADDR_WIDTH))          width_q  <= wr_data[WW-1:0];
            if (svc_wr)                              armed_q  <= (32'(wr_data) == KEY_ARM);
        end
    end

    assign tins = {tin_hi, tin_lo};

    // Per-half input conditioning and output shaping.
    for (genvar g = 0; g < NH; g++) begin : g_half
        st64_edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (tins[g]),
            .rise (rise[g])
        );
        assign tick[g] = ctrl_q[2+g] ? rise[g] : 1'b1;
        st64_out_shaper #(.WW(WW), .MIN_W(MIN_PULSE)) u_shape (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr),
            .evt        (evt[g]),
            .toggle_form(ctrl_q[4+g]),
            .width      (width_q),
            .pin        (pins[g])
        );
    end

    st64_counter #(.CW(CW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_q),
        .clr    (clr),
        .wd_load(wd_load),
        .svc_ok (svc_ok),
        .tick   (tick),
        .ld     (ld),
        .ld_val (wr_data),
        .prd    ({prd_hi_q, prd_lo_q}),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .evt    (evt),
        .expired(expired)
    );

    assign tout_lo  = pins[0];
    assign tout_hi  = pins[1];
    assign evt_lo   = evt[0];
    assign evt_hi   = evt[1];
    assign wdog_evt = expired;
    assign rst_req  = expired;
    assign rst_kind = ctrl_q[7:6];

    // Combinational register readback.
    always_comb begin
        unique case (rd_addr)
            AW'(ADDR_CTRL):   rd_data = CW'(ctrl_q);
            AW'(ADDR_PRD_LO): rd_data = prd_lo_q;
            AW'(ADDR_PRD_HI): rd_data = prd_hi_q;
            AW'(ADDR_CNT_LO): rd_data = cnt_lo;
            AW'(ADDR_CNT_HI): rd_data = cnt_hi;
            AW'(ADDR_WIDTH):  rd_data = CW'(width_q);
            default:          rd_data = '0;
        endcase
    end

    a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WDOG) |=> (mode_q == MODE_WDOG));
endmodule

// File: tb/tb_split_timer64.sv
`timescale 1ns/1ps
module tb_split_timer64;
    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tin_lo = 1'b0, tin_hi = 1'b0;
    logic        tout_lo, tout_hi, evt_lo, evt_hi, wdog_evt, rst_req;
    logic [1:0]  rst_kind;

    int n_cmp = 0, n_bad = 0, hi_glitch = 0;
    bit done = 0, mon_gen64 = 0;
    bit ext_on [2];
    int ext_half [2];
    int rises [2];

    split_timer64 dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 4'(a);
        #1 d = rd_data;
    endtask

    function automatic logic evt_of(input int w);
        return (w != 0) ? evt_hi : evt_lo;
    endfunction

    function automatic logic tout_of(input int w);
        return (w != 0) ? tout_hi : tout_lo;
    endfunction

    // Clocks until the next event of one half, and external edges seen meanwhile.
    task automatic wait_evt(input int w, input int maxc, output int cyc, output int edges);
        int start;
        start = rises[w];
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!evt_of(w) && cyc < maxc);
        edges = rises[w] - start;
    endtask

    task automatic high_len(input int w, output int len);
        int guard = 0;
        while (!tout_of(w) && guard < 2000) begin @(negedge clk); guard++; end
        len = 0;
        while (tout_of(w) && len < 2000) begin len++; @(negedge clk); end
    endtask

    task automatic low_len(input int w, output int len);
        len = 0;
        while (!tout_of(w) && len < 2000) begin len++; @(negedge clk); end
    endtask

    // External square-wave generators, driven just after each rising edge.
    initial begin
        int ctr [2];
        ctr[0] = 0; ctr[1] = 0;
        rises[0] = 0; rises[1] = 0;
        forever begin
            @(posedge clk);
            #1;
            for (int w = 0; w < 2; w++) begin
                if (ext_on[w]) begin
                    ctr[w]++;
                    if (ctr[w] >= ext_half[w]) begin
                        ctr[w] = 0;
                        if (w == 0) begin tin_lo = ~tin_lo; if (tin_lo) rises[0]++; end
                        else        begin tin_hi = ~tin_hi; if (tin_hi) rises[1]++; end
                    end
                end
            end
        end
    end

    // R5 monitor: high outputs must stay idle in 64-bit mode.
    initial forever begin
        @(negedge clk);
        if (mon_gen64 && (evt_hi || tout_hi)) hi_glitch++;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc, edges, len, p, a, b;
        void'($urandom(32'd4242));
        ext_on[0] = 0; ext_on[1] = 0; ext_half[0] = 12; ext_half[1] = 12;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 0);
        rd(3, v); check("R1 cnt_lo", v, 0);
        rd(4, v); check("R1 cnt_hi", v, 0);
        check("R1 outputs", {tout_lo, tout_hi, evt_lo, evt_hi, wdog_evt, rst_req}, 0);

        // R2 / R5: random periods, clock source, 64-bit mode
        mon_gen64 = 1;
        for (int r = 0; r < 5; r++) begin
            p = 3 + int'($urandom % 58);
            wr(0, 0); wr(1, p); wr(2, 0); wr(0, 1);
            wait_evt(0, 500, cyc, edges);
            wait_evt(0, 500, cyc, edges);
            check("R2 interval", cyc, p + 1);
            @(negedge clk);
            check("R2 single-cycle event", evt_lo, 0);
        end
        check("R5 high outputs idle", hi_glitch, 0);
        mon_gen64 = 0;

        // R2 carry across halves, R11 count load
        wr(0, 0); wr(3, 32'hFFFF_FFF0); wr(4, 0); wr(1, 32'h10); wr(2, 1); wr(0, 1);
        repeat (20) @(negedge clk);
        rd(3, v); check("R2 chained low", v, 4);
        rd(4, v); check("R2 chained high", v, 1);

        // R11 mode off clears and holds
        wr(0, 0);
        rd(3, v); check("R11 cleared low", v, 0);
        rd(4, v); check("R11 cleared high", v, 0);
        repeat (6) @(negedge clk);
        rd(3, v); check("R11 holds", v, 0);

        // R3 external edges, random half-periods
        for (int r = 0; r < 2; r++) begin
            p = 2 + int'($urandom % 4);
            ext_half[0] = 12 + int'($urandom % 6);
            wr(1, p); wr(2, 0); wr(0, 32'h5);
            ext_on[0] = 1;
            wait_evt(0, 3000, cyc, edges);
            wait_evt(0, 3000, cyc, edges);
            check("R3 edges per event", edges, p + 1);
            check("R3 cycles per event", cyc, (p + 1) * 2 * ext_half[0]);
            ext_on[0] = 0;
            repeat (8) @(negedge clk);
            rd(3, v);
            repeat (40) @(negedge clk);
            rd(3, a);
            check("R3 steady input holds count", a, v);
            wr(0, 0);
        end

        // R4 dual mode: low on clock, high on external edges
        for (int r = 0; r < 2; r++) begin
            a = 4 + int'($urandom % 30);
            b = 1 + int'($urandom % 4);
            ext_half[1] = 12 + int'($urandom % 5);
            wr(0, 0); wr(1, a); wr(2, b); wr(0, 32'hA);
            ext_on[1] = 1;
            wait_evt(0, 500, cyc, edges);
            wait_evt(0, 500, cyc, edges);
            check("R4 low interval", cyc, a + 1);
            wait_evt(1, 3000, cyc, edges);
            wait_evt(1, 3000, cyc, edges);
            check("R4 high edges per event", edges, b + 1);
            rd(4, v);
            check("R4 high count in range", (v <= b), 1);
            ext_on[1] = 0;
        end

        // R6 pulse widths
        wr(0, 0); wr(5, 5); wr(1, 60); wr(2, 0); wr(0, 1);
        high_len(0, len); check("R6 clamped pulse", len, 12);
        wr(5, 20);
        high_len(0, len); check("R6 programmed pulse", len, 20);

        // R7 toggle form
        p = 20 + int'($urandom % 20);
        wr(0, 0); wr(1, p); wr(0, 32'h11);
        high_len(0, len); check("R7 toggle high", len, p + 1);
        low_len(0, len);  check("R7 toggle low", len, p + 1);

        // Watchdog: fresh reset first
        wr(0, 0);
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
        wr(1, 100); wr(2, 0); wr(0, 32'h83);
        rd(0, v); check("R8 mode entered", v, 32'h83);
        wr(0, 0);
        rd(0, v); check("R10 ctrl write ignored", v, 32'h83);
        wr(3, 5);
        rd(3, v); check("R10 count write ignored", v, 96);
        wr(6, 32'hA5C6); wr(6, 32'hDA7E);
        rd(3, v); check("R9 valid service reloads", v, 100);
        wr(6, 32'hDA7E); wr(6, 32'hA5C6); wr(6, 32'h1234); wr(6, 32'hDA7E);
        rd(3, v); check("R9 bad sequence no reload", v, 92);
        repeat (91) @(negedge clk);
        check("R8 not yet expired", wdog_evt, 0);
        @(negedge clk);
        check("R8 expired", wdog_evt, 1);
        check("R8 reset request", rst_req, 1);
        check("R8 reset kind", rst_kind, 2);
        repeat (20) @(negedge clk);
        check("R8 expiry sticky", wdog_evt, 1);
        wr(6, 32'hA5C6); wr(6, 32'hDA7E);
        rd(3, v); check("R9 service after expiry ignored", v, 0);
        check("R8 still expired", wdog_evt, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule